// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory buffers. Software describes each buffer with a descriptor placed in a ring in memory. The engine reads the descriptor at its current position. If hardware owns that descriptor, the engine stores the next frame into the buffer the descriptor points to, writes back the stored length and a completion status, and steps to the next descriptor. A wrap flag on a descriptor sends the following fetch back to the ring base.

Software hands buffers back to the engine by setting the ownership flag again. It then restarts reception with a single-cycle kick. When the engine reaches a descriptor it does not own, it drops its active flag and waits for the next kick. Dropping the controller enable abandons the ring position. The next fetch after re-enabling comes from the ring base.

Top module: `rxd_ring_engine`

## Requirements
- R1: A descriptor is 8 bytes. The 32-bit word at its address holds the status in bits [31:16] and the length in bits [15:0]. The word at address+4 holds the buffer pointer.
- R2: A `kick` pulse while `ctl_enable` is high and the engine is idle raises `rx_active`. The engine then reads the status word of the current descriptor.
- R3: If status bit 15 (owned-by-hardware) is clear when fetched, the engine writes nothing. It clears `rx_active`, keeps `rx_ready` low, and stays idle until the next kick.
- R4: The bytes of a frame are written one per memory write, to pointer+0, pointer+1, and so on. Each write uses the single byte strobe of that address's lane.
- R5: On completion the status word is written back with bit 15 cleared, bit 11 (final buffer) set and bit 13 (wrap) unchanged. The length field equals the number of stored bytes, trailing CRC bytes included.
- R6: If the error marker accompanies the frame's last byte, status bit 0 is set in the written-back status.
- R7: Bytes beyond `max_len` are accepted and discarded. The length is written as `max_len` and status bit 1 (overrun) is set. A frame of exactly `max_len` bytes sets no overrun bit.
- R8: After a write-back, the next fetch is at the current address + 8. If the completed descriptor had its wrap bit set, the next fetch is at the ring base instead.
- R9: While `ctl_enable` is low, `rx_active` is low and kicks are ignored. The first fetch after re-enabling is at the ring base.
- R10: A memory request keeps `mem_req` high and `mem_addr` stable until `mem_ack`.
- R11: The low 4 bits of `ring_base` are ignored, so the ring always starts on a 16-byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller enable; low resets ring position |
| kick | input | 1 | Single-cycle restart of reception |
| ring_base | input | 32 | Ring start address (low 4 bits ignored) |
| max_len | input | 16 | Largest number of bytes stored per buffer |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_end | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame is bad (sampled with the last byte) |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_active | output | 1 | Engine is working the ring |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte lane strobes |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench fills a three-entry ring and sends frames that end cleanly, end with the error marker, overrun the buffer, and exactly fill it. It checks that a wrap bit brings the fetch back to the base, and that a write-back which dropped the wrap bit would lose the ring closure. It runs the engine into a descriptor it does not own, where a design that ignored ownership would overwrite a buffer software still holds. It also checks that toggling the enable restarts at the base and not at the stale position, and that a misaligned base is rounded down.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int ST_OWN  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_FIN  = 11;
  localparam int ST_OVR  = 1;
  localparam int ST_BAD  = 0;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef enum logic [2:0] {
    E_IDLE, E_GET_ST, E_GET_PTR, E_WAIT, E_PUT_BYTE, E_PUT_ST
  } eng_state_t;

  function automatic addr_t align_base(addr_t b, int unsigned bits);
    addr_t m;
    m = ~((addr_t'(1) << bits) - addr_t'(1));
    return b & m;
  endfunction

  function automatic addr_t next_desc(addr_t cur, addr_t base, logic wrap,
                                      int unsigned stride);
    return wrap ? base : cur + addr_t'(stride);
  endfunction

  function automatic logic [15:0] done_status(logic [15:0] fetched,
                                              logic ovr, logic bad);
    logic [15:0] s;
    s = 16'h0;
    s[ST_WRAP] = fetched[ST_WRAP];
    s[ST_FIN]  = 1'b1;
    s[ST_OVR]  = ovr;
    s[ST_BAD]  = bad;
    return s;
  endfunction

  function automatic logic [3:0] lane_strobe(logic [1:0] a);
    return 4'b0001 << a;
  endfunction
endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr
  import rxd_pkg::*;
#(
  parameter int unsigned STRIDE = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  addr_t base,
  input  logic  step,
  input  logic  wrap,
  output addr_t cur
);
  logic  fresh_q;
  addr_t cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      cur_q   <= '0;
    end else if (!enable) begin
      fresh_q <= 1'b1;
    end else if (step) begin
      cur_q   <= next_desc(cur, base, wrap, STRIDE);
      fresh_q <= 1'b0;
    end
  end

  assign cur = fresh_q ? base : cur_q;

  p_wrap_to_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step && wrap) |=> (!enable || cur == $past(base)));
  p_linear_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && step && !wrap) |=> (!enable || cur == $past(cur) + addr_t'(STRIDE)));
endmodule

// File: rtl/rxd_fill.sv
module rxd_fill
  import rxd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic spill,
  input  len_t max_len,
  output len_t cnt,
  output logic room,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovr <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ovr <= 1'b0;
    end else begin
      if (take)  cnt <= cnt + len_t'(1);
      if (spill) ovr <= 1'b1;
    end
  end

  assign room = (cnt < max_len);

  p_count_capped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(max_len) |-> cnt <= max_len || $past(cnt) > max_len);
  p_spill_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spill |-> !room);
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
  import rxd_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned DESC_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_enable,
  input  logic        kick,
  input  logic [31:0] ring_base,
  input  logic [15:0] max_len,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_end,
  input  logic        rx_err,
  output logic        rx_ready,
  output logic        rx_active,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_strb,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int unsigned PTR_OFS = DESC_BYTES / 2;

  eng_state_t  st_q;
  logic [15:0] stat_q;
  addr_t       buf_q;
  logic [7:0]  byte_q;
  logic        end_q, bad_q;
  addr_t       base_al, cur;
  len_t        cnt;
  logic        room, ovr;

  // named events for the assertions
  logic start_ev, miss_ev, own_ev, byte_in, take_ev, spill_ev, byte_done, wb_done;

  assign base_al   = align_base(ring_base, ALIGN_BITS);
  assign start_ev  = (st_q == E_IDLE) && ctl_enable && kick;
  assign miss_ev   = (st_q == E_GET_ST) && mem_ack && !mem_rdata[16+ST_OWN];
  assign own_ev    = (st_q == E_GET_ST) && mem_ack &&  mem_rdata[16+ST_OWN];
  assign byte_in   = (st_q == E_WAIT) && rx_valid;
  assign take_ev   = byte_in && room;
  assign spill_ev  = byte_in && !room;
  assign byte_done = (st_q == E_PUT_BYTE) && mem_ack;
  assign wb_done   = (st_q == E_PUT_ST) && mem_ack;

  rxd_ring_ptr #(.STRIDE(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .base(base_al),
    .step(wb_done), .wrap(stat_q[ST_WRAP]), .cur(cur)
  );

  rxd_fill u_fill (
    .clk(clk), .rst_n(rst_n),
    .clr((st_q == E_GET_PTR) && mem_ack),
    .take(byte_done), .spill(spill_ev), .max_len(max_len),
    .cnt(cnt), .room(room), .ovr(ovr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      stat_q <= '0;
      buf_q  <= '0;
      byte_q <= '0;
      end_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else if (!ctl_enable) begin
      st_q <= E_IDLE;
    end else begin
      unique case (st_q)
        E_IDLE: if (start_ev) st_q <= E_GET_ST;
        E_GET_ST: begin
          if (own_ev) begin
            stat_q <= mem_rdata[31:16];
            st_q   <= E_GET_PTR;
          end else if (miss_ev) begin
            st_q <= E_IDLE;
          end
        end
        E_GET_PTR: if (mem_ack) begin
          buf_q <= mem_rdata;
          bad_q <= 1'b0;
          st_q  <= E_WAIT;
        end
        E_WAIT: if (byte_in) begin
          byte_q <= rx_data;
          end_q  <= rx_end;
          if (rx_end) bad_q <= rx_err;
          if (room)        st_q <= E_PUT_BYTE;
          else if (rx_end) st_q <= E_PUT_ST;
        end
        E_PUT_BYTE: if (mem_ack) st_q <= end_q ? E_PUT_ST : E_WAIT;
        E_PUT_ST:   if (mem_ack) st_q <= E_GET_ST;
        default:    st_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    mem_strb  = 4'b0000;
    unique case (st_q)
      E_GET_ST:  mem_req = 1'b1;
      E_GET_PTR: begin
        mem_req  = 1'b1;
        mem_addr = cur + addr_t'(PTR_OFS);
      end
      E_PUT_BYTE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_q + addr_t'(cnt);
        mem_wdata = {4{byte_q}};
        mem_strb  = lane_strobe(mem_addr[1:0]);
      end
      E_PUT_ST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {done_status(stat_q, ovr, bad_q), cnt};
        mem_strb  = 4'b1111;
      end
      default: ;
    endcase
  end

  assign rx_ready  = (st_q == E_WAIT);
  assign rx_active = (st_q != E_IDLE);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && ctl_enable) |=>
      (!ctl_enable || (mem_req && $stable(mem_addr))));
  p_wb_gives_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |-> (!mem_wdata[16+ST_OWN] && mem_wdata[16+ST_FIN]));
  p_miss_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> !rx_active);
  p_ready_when_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_active);
  p_disable_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> !rx_active);
  p_kick_fetches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!ctl_enable || (mem_req && !mem_we && mem_addr == $past(cur))));
  p_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_PUT_BYTE) |-> $onehot0(mem_strb) && mem_strb != 4'b0000);
endmodule

// File: tb/rxd_ring_engine_test.sv
module rxd_ring_engine_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_enable = 1'b0, kick = 1'b0;
  logic [31:0] ring_base = 32'h47;
  logic [15:0] max_len = 16'd16;
  logic        rx_valid = 1'b0, rx_end = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = 8'h0;
  logic        rx_ready, rx_active, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0;
  logic [3:0]  mem_strb;
  logic        mem_ack = 1'b0;

  int checks = 0, errors = 0;
  int req_seen = 0;
  logic [7:0] mem [0:1023];
  logic [31:0] rd_log [$];
  logic [31:0] prev_addr = 32'h0;
  logic prev_pend = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  rxd_ring_engine uut (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .kick(kick),
    .ring_base(ring_base), .max_len(max_len), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .rx_err(rx_err), .rx_ready(rx_ready),
    .rx_active(rx_active), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_strb(mem_strb),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and handshake monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pend && ctl_enable && (!mem_req || mem_addr != prev_addr))
        check(1'b0, "R10 request dropped or moved", mem_addr, prev_addr);
      if (mem_req) req_seen++;
      if (mem_ack) begin
        mem_ack = 1'b0;
        prev_pend = 1'b0;
      end else if (mem_req) begin
        int a;
        a = int'(mem_addr[9:0]) & ~3;
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_strb[k]) mem[a+k] = mem_wdata[8*k +: 8];
        end else begin
          mem_rdata = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
          rd_log.push_back(mem_addr);
        end
        mem_ack = 1'b1;
        prev_pend = 1'b0;
      end else prev_pend = 1'b0;
      if (mem_req && !mem_ack) begin prev_pend = 1'b1; prev_addr = mem_addr; end
    end
  end

  function automatic logic [31:0] rd_word(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr_word(int a, logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[a+k] = w[8*k +: 8];
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic send(int n, logic [7:0] first, bit bad);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rx_ready) @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = first + 8'(i);
      rx_end   = (i == n-1);
      rx_err   = bad && (i == n-1);
      @(negedge clk);
      rx_valid = 1'b0; rx_end = 1'b0; rx_err = 1'b0;
    end
  endtask

  task automatic wait_done(int a);
    while (mem[a+3][7]) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (rx_active) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_bytes(int a, int n, logic [7:0] first, string tag);
    for (int i = 0; i < n; i++)
      check(mem[a+i] == first + 8'(i), tag, 32'(mem[a+i]), 32'(first + 8'(i)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'hEE;
    // ring at 0x40 (base input 0x47 rounds down, R11), three descriptors (R1)
    wr_word(32'h40, 32'h8000_0000); wr_word(32'h44, 32'h100);
    wr_word(32'h48, 32'h8000_0000); wr_word(32'h4C, 32'h140);
    wr_word(32'h50, 32'hA000_0000); wr_word(32'h54, 32'h180);
    repeat (3) @(negedge clk);
    check(!rx_active && !rx_ready && !mem_req, "reset state", {rx_active, rx_ready, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk); ctl_enable = 1'b1;
    pulse_kick();
    check(rx_active, "R2 kick raises active", rx_active, 1);

    send(10, 8'h10, 1'b0);
    wait_done(32'h40);
    check(rd_log[0] == 32'h40, "R2 R11 first fetch at aligned base", rd_log[0], 32'h40);
    check(rd_log[1] == 32'h44, "R1 pointer word fetched", rd_log[1], 32'h44);
    check(rd_word(32'h40) == 32'h0800_000A, "R5 clean completion", rd_word(32'h40), 32'h0800_000A);
    check_bytes(32'h100, 10, 8'h10, "R4 frame A bytes");
    check(mem[32'h10A] == 8'hEE, "R4 no byte past frame A", 32'(mem[32'h10A]), 32'hEE);

    send(20, 8'h30, 1'b0);
    wait_done(32'h48);
    check(rd_word(32'h48) == 32'h0802_0010, "R7 overrun length and flag", rd_word(32'h48), 32'h0802_0010);
    check_bytes(32'h140, 16, 8'h30, "R7 truncated bytes");
    check(mem[32'h150] == 8'hEE, "R7 excess byte discarded", 32'(mem[32'h150]), 32'hEE);
    check(rd_log[2] == 32'h48, "R8 linear step", rd_log[2], 32'h48);

    send(8, 8'h50, 1'b1);
    wait_done(32'h50);
    check(rd_word(32'h50) == 32'h2801_0008, "R6 R5 error flag and wrap kept", rd_word(32'h50), 32'h2801_0008);
    wait_idle();
    check(rd_log[rd_log.size()-1] == 32'h40, "R8 wrap returns to base", rd_log[rd_log.size()-1], 32'h40);
    check(!rx_active && !rx_ready, "R3 not-owned descriptor idles", {rx_active, rx_ready}, 0);
    check(rd_word(32'h40) == 32'h0800_000A, "R3 not-owned descriptor untouched", rd_word(32'h40), 32'h0800_000A);

    wr_word(32'h40, 32'h8000_0000);
    pulse_kick();
    send(4, 8'h70, 1'b0);
    wait_done(32'h40);
    check(rd_word(32'h40) == 32'h0800_0004, "R3 restart by kick", rd_word(32'h40), 32'h0800_0004);
    check_bytes(32'h100, 4, 8'h70, "R4 frame D bytes");
    check(mem[32'h104] == 8'h14, "R4 old byte kept", 32'(mem[32'h104]), 32'h14);
    wait_idle();
    check(rd_log[rd_log.size()-1] == 32'h48, "R3 stop at next not-owned", rd_log[rd_log.size()-1], 32'h48);

    // enable toggle resets position to base (R9)
    wr_word(32'h40, 32'h8000_0000); wr_word(32'h48, 32'h8000_0000);
    @(negedge clk); ctl_enable = 1'b0;
    repeat (2) @(negedge clk); ctl_enable = 1'b1;
    pulse_kick();
    send(3, 8'h90, 1'b0);
    wait_done(32'h40);
    check(rd_word(32'h40) == 32'h0800_0003, "R9 restart at base", rd_word(32'h40), 32'h0800_0003);
    check(rd_word(32'h48) == 32'h8000_0000, "R9 stale slot unused", rd_word(32'h48), 32'h8000_0000);

    @(negedge clk); ctl_enable = 1'b0;
    @(negedge clk);
    check(!rx_active, "R9 disable clears active", rx_active, 0);
    req_seen = 0;
    pulse_kick();
    repeat (20) @(negedge clk);
    check(!rx_active && req_seen == 0, "R9 kick ignored while disabled", req_seen, 0);

    // exact fill: no overrun (R7 boundary)
    wr_word(32'h40, 32'h8000_0000);
    ctl_enable = 1'b1;
    pulse_kick();
    send(16, 8'hA0, 1'b0);
    wait_done(32'h40);
    check(rd_word(32'h40) == 32'h0800_0010, "R7 exact fill no overrun", rd_word(32'h40), 32'h0800_0010);
    check_bytes(32'h100, 16, 8'hA0, "R7 exact fill bytes");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule